// File: doc/BRIEF.md
# Segmented Next-Hop Lookup Unit

This block is a single lane of a parallel route-lookup engine. Destination addresses arrive already sorted by the module-identifier bits, each with a short tag, in a first-word-fall-through FIFO that sits outside the block. The unit reads one address at a time from that FIFO. It uses the high address bits to read a segment table. The segment entry either supplies the next hop itself or gives a base pointer into a next-hop array. In the second case the low sixteen address bits select a word of that array, either by direct indexing or through a compressed, bitmap-counted layout.

Each finished result is placed in an eight-deep output buffer together with the tag of its address. A downstream merger drains the buffer and uses the tag to re-associate results from all lanes. When the buffer is full the unit holds its finished result and takes no new address until space opens. Both tables are internal synchronous memories, filled through a one-word write port.

Bit numbering in this brief is zero-based from the least significant bit: `addr[31]` is the leftmost address bit.

Top module: `lookup_unit`

## Requirements
- R1: During reset and after reset is released, the output buffer is empty (`outValid` low). `inPop` stays low while `inEmpty` is high.
- R2: The unit pops an address (`inPop` high for one cycle) only when `inEmpty` is low and no earlier lookup is still in flight, so at most one lookup is active at a time. While `inEmpty` is high it waits.
- R3: The segment-table index is `addr[18 +: SEG_IDX_W]`, the low bits of the 14-bit field `addr[31:18]`. Bits `addr[17:16]` (the lane identifier) and the field bits above the index do not change the result.
- R4: A segment entry is `[31]` direct flag, `[30:27]` offset length, `[26:0]` next hop or array base pointer. With the flag set, the result is `entry[26:0]` whatever the length field holds. It is pushed two cycles after the pop cycle and is visible on the output one cycle later.
- R5: With the flag clear and length L ≤ 3, let `chunk = addr[15:0] >> (16-L)` (0 when L=0). The array is read at `(base + chunk) mod 2^NHA_AW`. The result is pushed three cycles after the pop cycle.
- R6: With the flag clear and L > 3, the unit first reads a bitmap word at `base + (chunk >> 4)`. That word holds a run base in `[26:16]` and a bitmap in `[15:0]`. The unit then reads the next hop at `base + runBase + (number of set bitmap bits below position chunk[3:0])`, all modulo `2^NHA_AW`. The extra access costs one cycle, so the push comes four cycles after the pop cycle.
- R7: Every result leaves the buffer with the tag of the address that produced it, and results leave in the order their addresses were popped.
- R8: The output buffer holds up to 8 results. `outValid` is high while it is non-empty, and `outHop`/`outTag` show the oldest result. When it is full and `outPop` is low, the finished result is held (never overwritten or lost) and no new address is popped.
- R9: When the buffer is full, a push and an `outPop` in the same cycle both take effect: the oldest result leaves, the new one enters, and the occupancy stays at 8.
- R10: A write with `wrTable`=0 stores `wrData` into segment entry `wrAddr[SEG_IDX_W-1:0]`. A write with `wrTable`=1 stores `wrData[26:0]` into array word `wrAddr[NHA_AW-1:0]`. Lookups started after a write use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inEmpty | input | 1 | Address FIFO is empty |
| inAddr | input | 32 | Head address of the FIFO |
| inTag | input | TAG_W | Head tag of the FIFO |
| inPop | output | 1 | Takes the head entry of the FIFO |
| wrEn | input | 1 | Table write strobe |
| wrTable | input | 1 | 0 selects the segment table, 1 selects the next-hop array |
| wrAddr | input | max(SEG_IDX_W, NHA_AW) | Write word address |
| wrData | input | 32 | Write data |
| outPop | input | 1 | Consumer removes the oldest result |
| outValid | output | 1 | Output buffer holds at least one result |
| outHop | output | 27 | Next hop of the oldest result |
| outTag | output | TAG_W | Tag of the oldest result |

## Verification
The two functions that can meet in one cycle are the lookup's push into the output buffer and the consumer's removal from it. The hard case is a full buffer. To provoke it, the bench holds `outPop` low until eight results are queued and a ninth is parked. It then raises `outPop` for a single cycle, so the parked result enters while the oldest leaves. A behavioural queue model in the bench predicts `inPop`, `outValid` and the head result on every cycle, so a lost, duplicated or reordered result shows up as a mismatch at the ports.

// File: rtl/lookup_pkg.sv
package lookup_pkg;

  localparam int ADDR_W  = 32;
  localparam int ENTRY_W = 32;
  localparam int NH_W    = 27;
  localparam int LEN_W   = 4;
  localparam int OFS_W   = 16;
  localparam int BMAP_W  = 16;
  localparam int RUN_W   = NH_W - BMAP_W;
  localparam int SEG_LSB = 18;
  localparam int CMP_MIN = 4;   // lengths at or above this use the compressed layout

  // segment table word
  typedef struct packed {
    logic             direct;
    logic [LEN_W-1:0] len;
    logic [NH_W-1:0]  field;
  } segEntry_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic issueArr;
    logic issueHop;
    logic takeDirect;
    logic takeArr;
    logic push;
  } lkStrobe_t;

  // number of set bits in bm strictly below position pos
  function automatic logic [4:0] popBelow(input logic [BMAP_W-1:0] bm,
                                          input logic [3:0] pos);
    logic [4:0] cnt;
    cnt = '0;
    for (int i = 0; i < BMAP_W; i++) begin
      if (i < int'(pos) && bm[i]) cnt = cnt + 5'd1;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/lookup_ctrl.sv
module lookup_ctrl
  import lookup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inEmpty,
  input  logic      isDirect,
  input  logic      isCompressed,
  input  logic      bufFull,
  input  logic      outPop,
  output logic      inPop,
  output lkStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_BMAP,
    ST_ARR,
    ST_PUSH
  } lkState_t;

  lkState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    inPop     = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (!inEmpty) begin
          inPop          = 1'b1;
          strobe.capture = 1'b1;
          stateNext      = ST_SEG;
        end
      end
      ST_SEG: begin
        if (isDirect) begin
          strobe.takeDirect = 1'b1;
          stateNext         = ST_PUSH;
        end else begin
          strobe.issueArr = 1'b1;
          stateNext       = isCompressed ? ST_BMAP : ST_ARR;
        end
      end
      ST_BMAP: begin
        strobe.issueHop = 1'b1;
        stateNext       = ST_ARR;
      end
      ST_ARR: begin
        strobe.takeArr = 1'b1;
        stateNext      = ST_PUSH;
      end
      ST_PUSH: begin
        if (!bufFull || outPop) begin
          strobe.push = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // one lookup in flight: a pop is never followed by another pop
  assert_single_flight_R2: assert property (@(posedge clk) disable iff (!rstN)
    inPop |=> !inPop);

endmodule

// File: rtl/lookup_dpath.sv
module lookup_dpath
  import lookup_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int SEG_IDX_W = 8,
  parameter int NHA_AW    = 8,
  localparam int WR_AW    = (SEG_IDX_W > NHA_AW) ? SEG_IDX_W : NHA_AW
)(
  input  logic              clk,
  input  logic              rstN,
  input  lkStrobe_t         strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              wrEn,
  input  logic              wrTable,
  input  logic [WR_AW-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output logic              isDirect,
  output logic              isCompressed,
  output logic [NH_W-1:0]   resHop,
  output logic [TAG_W-1:0]  resTag
);

  localparam int SEG_DEPTH = 1 << SEG_IDX_W;
  localparam int ARR_DEPTH = 1 << NHA_AW;

  logic [ENTRY_W-1:0] segMem [SEG_DEPTH];
  logic [NH_W-1:0]    arrMem [ARR_DEPTH];

  logic [ENTRY_W-1:0] segQ;
  logic [NH_W-1:0]    arrQ;
  logic [OFS_W-1:0]   ofsReg;
  logic [TAG_W-1:0]   tagReg;
  segEntry_t          ent;
  logic [4:0]         shAmt;
  logic [OFS_W-1:0]   chunkIdx;
  logic [OFS_W-1:0]   stepIdx;
  logic [4:0]         belowCnt;
  logic [31:0]        sumFirst;
  logic [31:0]        sumHop;
  logic [NHA_AW-1:0]  firstAddr;
  logic [NHA_AW-1:0]  hopAddr;
  logic               unusedBits;

  // table write port
  always_ff @(posedge clk) begin
    if (wrEn && !wrTable) segMem[wrAddr[SEG_IDX_W-1:0]] <= wrData;
    if (wrEn &&  wrTable) arrMem[wrAddr[NHA_AW-1:0]]    <= wrData[NH_W-1:0];
  end

  // segment read, launched with the pop
  always_ff @(posedge clk) begin
    if (strobe.capture) segQ <= segMem[inAddr[SEG_LSB +: SEG_IDX_W]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ofsReg <= '0;
      tagReg <= '0;
    end else if (strobe.capture) begin
      ofsReg <= inAddr[OFS_W-1:0];
      tagReg <= inTag;
    end
  end

  assign ent          = segEntry_t'(segQ);
  assign isDirect     = ent.direct;
  assign isCompressed = (ent.len >= LEN_W'(CMP_MIN));

  // chunk index: top len bits of the offset
  assign shAmt    = 5'd16 - {1'b0, ent.len};
  assign chunkIdx = ofsReg >> shAmt;
  assign stepIdx  = isCompressed ? {4'd0, chunkIdx[OFS_W-1:4]} : chunkIdx;
  assign sumFirst = {5'd0, ent.field} + {16'd0, stepIdx};
  assign firstAddr = sumFirst[NHA_AW-1:0];

  // compressed hop address from the bitmap word
  assign belowCnt = popBelow(arrQ[BMAP_W-1:0], chunkIdx[3:0]);
  assign sumHop   = {5'd0, ent.field} + {{(32-RUN_W){1'b0}}, arrQ[NH_W-1:BMAP_W]}
                  + {27'd0, belowCnt};
  assign hopAddr  = sumHop[NHA_AW-1:0];

  always_ff @(posedge clk) begin
    if (strobe.issueArr)      arrQ <= arrMem[firstAddr];
    else if (strobe.issueHop) arrQ <= arrMem[hopAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  resHop <= '0;
    else if (strobe.takeDirect) resHop <= ent.field;
    else if (strobe.takeArr)    resHop <= arrQ;
  end

  assign resTag     = tagReg;
  assign unusedBits = ^{inAddr, sumFirst, sumHop};

  // direct entries finish in the cycle right after the segment read
  assert_direct_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeDirect |-> $past(strobe.capture));

  // compressed hop read always follows the bitmap-word read
  assert_bitmap_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueHop |-> $past(strobe.issueArr));

  // an array result is only taken right after an array read was launched
  assert_array_take_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeArr |-> ($past(strobe.issueArr) || $past(strobe.issueHop)));

endmodule

// File: rtl/lookup_outbuf.sv
module lookup_outbuf #(
  parameter int WIDTH = 31,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic             valid,
  output logic             full,
  output logic [WIDTH-1:0] popData
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             doPop;

  assign doPop   = pop && (count != '0);
  assign valid   = (count != '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign popData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push)  wrPtr <= nextPtr(wrPtr);
      if (doPop) rdPtr <= nextPtr(rdPtr);
      unique case ({push, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |-> pop);

  assert_full_swap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (push && doPop && full) |=> full);

endmodule

// File: rtl/lookup_unit.sv
module lookup_unit
  import lookup_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int SEG_IDX_W = 8,
  parameter int NHA_AW    = 8,
  parameter int OUT_DEPTH = 8,
  localparam int WR_AW    = (SEG_IDX_W > NHA_AW) ? SEG_IDX_W : NHA_AW
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inEmpty,
  input  logic [ADDR_W-1:0]  inAddr,
  input  logic [TAG_W-1:0]   inTag,
  output logic               inPop,
  input  logic               wrEn,
  input  logic               wrTable,
  input  logic [WR_AW-1:0]   wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic               outPop,
  output logic               outValid,
  output logic [NH_W-1:0]    outHop,
  output logic [TAG_W-1:0]   outTag
);

  localparam int RES_W = NH_W + TAG_W;

  lkStrobe_t          strobe;
  logic               isDirect;
  logic               isCompressed;
  logic               bufFull;
  logic [NH_W-1:0]    resHop;
  logic [TAG_W-1:0]   resTag;
  logic [RES_W-1:0]   headWord;

  lookup_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inEmpty      (inEmpty),
    .isDirect     (isDirect),
    .isCompressed (isCompressed),
    .bufFull      (bufFull),
    .outPop       (outPop),
    .inPop        (inPop),
    .strobe       (strobe)
  );

  lookup_dpath #(
    .TAG_W     (TAG_W),
    .SEG_IDX_W (SEG_IDX_W),
    .NHA_AW    (NHA_AW)
  ) i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .inAddr       (inAddr),
    .inTag        (inTag),
    .wrEn         (wrEn),
    .wrTable      (wrTable),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .isDirect     (isDirect),
    .isCompressed (isCompressed),
    .resHop       (resHop),
    .resTag       (resTag)
  );

  lookup_outbuf #(
    .WIDTH (RES_W),
    .DEPTH (OUT_DEPTH)
  ) i_outbuf (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.push),
    .pushData ({resHop, resTag}),
    .pop      (outPop),
    .valid    (outValid),
    .full     (bufFull),
    .popData  (headWord)
  );

  assign outHop = headWord[RES_W-1:TAG_W];
  assign outTag = headWord[TAG_W-1:0];

endmodule

// File: tb/test_lookup_unit.sv
`timescale 1ns/1ps
module test_lookup_unit;

  localparam int TAG_W = 4;
  localparam time TCLK = 20ns;

  typedef struct {
    int    hop;
    int    tag;
    string rq;
  } res_t;

  typedef struct {
    logic [31:0] addr;
    int          tag;
  } req_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inEmpty = 1'b1;
  logic [31:0] inAddr = '0;
  logic [TAG_W-1:0] inTag = '0;
  logic        inPop;
  logic        wrEn = 1'b0;
  logic        wrTable = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        outPop = 1'b0;
  logic        outValid;
  logic [26:0] outHop;
  logic [TAG_W-1:0] outTag;

  lookup_unit i_lookup_unit (
    .clk(clk), .rstN(rstN), .inEmpty(inEmpty), .inAddr(inAddr), .inTag(inTag),
    .inPop(inPop), .wrEn(wrEn), .wrTable(wrTable), .wrAddr(wrAddr), .wrData(wrData),
    .outPop(outPop), .outValid(outValid), .outHop(outHop), .outTag(outTag)
  );

  always #(TCLK/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  logic [31:0] segS [256];
  logic [26:0] arrS [256];
  req_t  reqQ[$];
  res_t  q[$];
  bit    pendPop = 0;
  bit    mBusy = 0;
  int    mLeft = 0;
  res_t  mRes;
  bit    holdIn = 0;
  bit    wrPend = 0;
  bit    wrPendTbl;
  int    wrPendAddr;
  logic [31:0] wrPendData;
  string phaseReq = "R2";
  int    tagSeq = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkSeg(input bit d, input int len, input int fld);
    return {d, 4'(len), 27'(fld)};
  endfunction

  function automatic logic [31:0] mkAddr(input int hi, input int seg, input int id, input int ofs);
    return {6'(hi), 8'(seg), 2'(id), 16'(ofs)};
  endfunction

  // expected result from the requirements (R3..R6)
  task automatic predict(input logic [31:0] a, output int hop, output int lat, output string rq);
    logic [31:0] e;
    int len, base, ofs, chunk, w, run, pc;
    e    = segS[a[25:18]];                    // R3
    len  = int'(e[30:27]);
    base = int'(e[26:0]);
    ofs  = int'(a[15:0]);
    chunk = (len == 0) ? 0 : (ofs >> (16 - len));
    if (e[31]) begin                          // R4
      hop = int'(e[26:0]); lat = 1; rq = "R4";
    end else if (len <= 3) begin              // R5
      hop = int'(arrS[(base + chunk) % 256]); lat = 2; rq = "R5";
    end else begin                            // R6
      w   = int'(arrS[(base + chunk / 16) % 256]);
      run = (w >> 16) & 2047;
      pc  = 0;
      for (int j = 0; j < (chunk % 16); j++) if (w[j]) pc++;
      hop = int'(arrS[(base + run + pc) % 256]); lat = 3; rq = "R6";
    end
  endtask

  task automatic step(input bit popIt);
    bit expPop, mPop, mPush;
    int hop, lat;
    string rq;
    @(negedge clk);
    if (pendPop) begin void'(reqQ.pop_front()); pendPop = 0; end
    outPop = popIt;
    wrEn   = wrPend;
    if (wrPend) begin
      wrTable = wrPendTbl; wrAddr = 8'(wrPendAddr); wrData = wrPendData;
      wrPend = 0;
    end
    inEmpty = (reqQ.size() == 0) || holdIn;
    if (reqQ.size() != 0) begin inAddr = reqQ[0].addr; inTag = TAG_W'(reqQ[0].tag); end
    #1;
    expPop = !mBusy && !inEmpty;
    check(inPop == expPop, phaseReq, "inPop", int'(inPop), int'(expPop));
    check(outValid == (q.size() != 0), "R8", "outValid", int'(outValid), int'(q.size() != 0));
    if (q.size() != 0 && outValid) begin
      check(int'(outHop) == q[0].hop, q[0].rq, "outHop", int'(outHop), q[0].hop);
      check(int'(outTag) == q[0].tag, "R7", "outTag", int'(outTag), q[0].tag);
    end
    // advance the model across the coming edge
    mPop  = popIt && (q.size() != 0);
    mPush = mBusy && (mLeft == 0) && (q.size() < 8 || popIt);
    if (mPop) void'(q.pop_front());
    if (mPush) begin q.push_back(mRes); mBusy = 0; end
    else if (mBusy && mLeft > 0) mLeft--;
    if (expPop) begin
      predict(reqQ[0].addr, hop, lat, rq);
      mRes.hop = hop; mRes.tag = reqQ[0].tag; mRes.rq = rq;
      mBusy = 1; mLeft = lat; pendPop = 1;
    end
  endtask

  task automatic writeWord(input bit tbl, input int a, input logic [31:0] d);
    wrPend = 1; wrPendTbl = tbl; wrPendAddr = a; wrPendData = d;
    if (tbl) arrS[a] = d[26:0]; else segS[a] = d;   // R10
    step(1'b0);
  endtask

  task automatic lookup(input logic [31:0] a);
    req_t r;
    r.addr = a; r.tag = tagSeq % 16; tagSeq++;
    reqQ.push_back(r);
  endtask

  task automatic drain(input bit popIt);
    int n = 0;
    while ((reqQ.size() != 0 || mBusy || q.size() != 0 || pendPop) && n < 2000) begin
      step(popIt); n++;
    end
    check(q.size() == 0 && !mBusy, phaseReq, "drained", q.size(), 0);
  endtask

  initial begin
    #(TCLK * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(inPop == 1'b0, "R1", "inPop in reset", int'(inPop), 0);
    rstN = 1'b1;
    step(1'b0);
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);

    // R10: fill both tables
    for (int i = 0; i < 256; i++) writeWord(1'b0, i, mkSeg(1, 0, 27'h50000 + i));
    for (int i = 0; i < 256; i++) writeWord(1'b1, i, 32'(27'h400000 + i * 7));

    writeWord(1'b0, 1, mkSeg(1, 9, 27'h1234567));   // direct, length ignored
    writeWord(1'b0, 2, mkSeg(0, 2, 10));
    writeWord(1'b0, 3, mkSeg(0, 0, 20));
    writeWord(1'b0, 4, mkSeg(0, 6, 40));
    writeWord(1'b1, 40, {5'd0, 11'd4, 16'h9105});
    writeWord(1'b1, 41, {5'd0, 11'd9, 16'h00FF});
    writeWord(1'b1, 42, {5'd0, 11'd3, 16'hFFFF});
    writeWord(1'b1, 43, {5'd0, 11'd0, 16'h0001});
    writeWord(1'b0, 5, mkSeg(0, 15, 100));
    writeWord(1'b0, 6, mkSeg(0, 3, 254));
    writeWord(1'b0, 7, mkSeg(0, 4, 200));
    writeWord(1'b1, 200, {5'd0, 11'd1, 16'hA5A5});

    // directed single lookups (R3..R6)
    phaseReq = "R2";
    lookup(mkAddr(0, 1, 0, 16'h0000));  drain(1'b1);   // R4 direct
    lookup(mkAddr(0, 2, 1, 16'hC000));  drain(1'b1);   // R5 len 2
    lookup(mkAddr(0, 3, 2, 16'hFFFF));  drain(1'b1);   // R5 len 0
    lookup(mkAddr(0, 6, 3, 16'hE000));  drain(1'b1);   // R5 wrap
    lookup(mkAddr(0, 4, 0, 16'h1C00));  drain(1'b1);   // R6 word 0 bit 7
    lookup(mkAddr(0, 4, 0, 16'h7C00));  drain(1'b1);   // R6 word 1 bit 15
    lookup(mkAddr(0, 7, 0, 16'hF000));  drain(1'b1);   // R6 single word
    lookup(mkAddr(0, 5, 0, 16'h8642));  drain(1'b1);   // R6 len 15
    // R3: upper field bits and lane id ignored
    lookup(mkAddr(6'h2A, 2, 3, 16'h4000)); drain(1'b1);
    lookup(mkAddr(6'h3F, 4, 1, 16'h1C00)); drain(1'b1);

    // back-to-back mixed traffic (R2, R7)
    seed = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      lookup(mkAddr(int'(seed[31:26]), int'(seed[10:8]), int'(seed[13:12]), int'(seed[27:12])));
    end
    drain(1'b1);

    // R8: fill the buffer and stall
    phaseReq = "R8";
    for (int i = 0; i < 11; i++) lookup(mkAddr(0, 1 + (i % 7), i % 4, i * 16'h1357));
    for (int i = 0; i < 80; i++) step(1'b0);
    check(q.size() == 8 && outValid, "R8", "buffer full", int'(outValid), 1);
    // R9: one pop while a finished result waits
    phaseReq = "R9";
    step(1'b1);
    for (int i = 0; i < 6; i++) step(1'b0);
    check(q.size() == 8, "R9", "occupancy after swap", q.size(), 8);
    drain(1'b1);

    // R10: rewrite entries and look up again
    phaseReq = "R10";
    writeWord(1'b0, 2, mkSeg(1, 0, 27'h7654321));
    writeWord(1'b1, 20, 32'h0ABCDEF);
    lookup(mkAddr(0, 2, 0, 16'h0000)); drain(1'b1);
    lookup(mkAddr(0, 3, 0, 16'h1234)); drain(1'b1);

    // R2: waits while the input side is empty
    phaseReq = "R2";
    holdIn = 1;
    lookup(mkAddr(0, 1, 0, 0));
    for (int i = 0; i < 5; i++) step(1'b1);
    holdIn = 0;
    drain(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule